// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small fully associative translation cache placed in front of a data cache. Each cycle it can take one lookup: a virtual address, the current context ID and an access kind (load, store or fetch). In the same cycle it returns the physical address, a hit flag and a permission fault flag. Pages are 4 KiB. The low twelve address bits are the page offset and pass straight through. Only the upper bits are translated.

Each entry holds a virtual page number, a context tag, a global flag, a physical page number and three permission bits. When a lookup misses, the block raises a walk request toward an external page table walker. The walker later answers through a fill port. A good answer is written into the cache. A failed answer produces a page fault that carries the virtual address of the most recent miss. Writing the page-table base register strobes a flush. The flush drops every entry that is not global, so translations belonging to another process can no longer hit.

Top module: `ctx_tlb`

## Requirements
- R1: On a hit, `resp_paddr` is the entry's physical page number followed by `req_vaddr[11:0]` unchanged, and it is valid in the same cycle as the request.
- R2: A valid lookup that does not hit gives `resp_hit`=0 and `resp_paddr`=0, and raises `walk_req` with `walk_vpn` equal to the request's page number.
- R3: A non-global entry hits only when its context tag equals `req_ctx`. A global entry hits under any context.
- R4: A cycle with `base_wr`=1 invalidates every non-global entry and keeps the global ones. Any lookup in that same cycle reports a miss.
- R5: A fill with `fill_valid`=1 and `fill_ok`=1 is stored at the clock edge, so that a lookup of the same page and context on a later cycle hits.
- R6: The permission bits are bit 0 read, bit 1 write and bit 2 execute. `req_kind` is 0 for load, 1 for store and 2 for fetch; the value 3 is treated as a load. A hit whose needed bit is clear raises `resp_perm_fault` while `resp_hit` stays 1.
- R7: A fill with `fill_valid`=1 and `fill_ok`=0 raises `page_fault` in that cycle. `fault_vaddr` then carries the full virtual address of the last missed lookup. Nothing is inserted.
- R8: While any entry is invalid, a new fill goes into the lowest-numbered invalid entry and evicts nothing.
- R9: When all entries are valid, a new fill replaces the entry selected by a round-robin pointer. The pointer starts at entry 0 after reset and steps by one for each such replacement.
- R10: A fill whose page already has a matching entry overwrites that entry. The old physical page is no longer returned, and a lookup never matches two entries.
- R11: After reset every entry is invalid, and `resp_hit` and `page_fault` are 0.
- R12: When `req_valid`=0, `resp_hit`, `resp_perm_fault` and `walk_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup present this cycle |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_ctx | input | CTX_W | Current context ID |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| resp_hit | output | 1 | Translation found |
| resp_paddr | output | PA_W | Translated physical address (0 on miss) |
| resp_perm_fault | output | 1 | Hit without the needed permission |
| walk_req | output | 1 | Miss: page table walk wanted |
| walk_vpn | output | VA_W-12 | Page number to walk |
| fill_valid | input | 1 | Walker answer present |
| fill_ok | input | 1 | Walker found a valid mapping |
| fill_vpn | input | VA_W-12 | Virtual page of the answer |
| fill_ctx | input | CTX_W | Context tag of the answer |
| fill_global | input | 1 | Answer is shared by all contexts |
| fill_ppn | input | PA_W-12 | Physical page of the answer |
| fill_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| base_wr | input | 1 | Page-table base register written: flush non-global entries |
| page_fault | output | 1 | Walk found no mapping |
| fault_vaddr | output | VA_W | Virtual address of the faulting miss |

## Verification
Corrupted stored state does not appear at the ports until a lookup touches it, and then it shows up in that same cycle. A lost valid bit shows as a miss with a walk request. A stale entry left behind by a flush or a bad context compare shows as a hit under the wrong context. A duplicate entry shows as a wrong physical page. A wrong victim choice stays hidden until a lookup of the page that was wrongly evicted: that lookup misses, while the page that should have been evicted still hits. The bench therefore fills the array to capacity and probes both the evicted page and the pages that should survive after each replacement.

// File: rtl/ctx_tlb_pkg.sv
`timescale 1ns/1ps
package ctx_tlb_pkg;
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   localparam int PERM_BITS = 3;
   localparam int PERM_RD   = 0;
   localparam int PERM_WR   = 1;
   localparam int PERM_EX   = 2;
endpackage

// File: rtl/ctx_tlb_cam.sv
`timescale 1ns/1ps
module ctx_tlb_cam #(
   parameter int DEPTH = 16,
   parameter int VPN_W = 20,
   parameter int CTX_W = 8
) (
   input  logic [DEPTH-1:0]         ent_valid,
   input  logic [DEPTH-1:0]         ent_global,
   input  logic [VPN_W-1:0]         ent_vpn [DEPTH],
   input  logic [CTX_W-1:0]         ent_ctx [DEPTH],
   input  logic [VPN_W-1:0]         key_vpn,
   input  logic [CTX_W-1:0]         key_ctx,
   input  logic                     key_any_ctx,
   output logic [DEPTH-1:0]         match_vec,
   output logic                     match_any,
   output logic [$clog2(DEPTH)-1:0] match_idx
);
   localparam int IDX_W = $clog2(DEPTH);

   // one comparator per entry, all in parallel
   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_cmp
         logic vpn_eq, ctx_ok;
         assign vpn_eq       = (ent_vpn[g] == key_vpn);
         assign ctx_ok       = ent_global[g] || key_any_ctx || (ent_ctx[g] == key_ctx);
         assign match_vec[g] = ent_valid[g] && vpn_eq && ctx_ok;
      end
   endgenerate

   assign match_any = |match_vec;

   // OR-encoder: exact when at most one bit is set
   always_comb begin
      match_idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (match_vec[i]) match_idx = match_idx | IDX_W'(i);
      end
   end
endmodule

// File: rtl/ctx_tlb_victim.sv
`timescale 1ns/1ps
module ctx_tlb_victim #(
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [DEPTH-1:0]         ent_valid,
   input  logic                     take,
   output logic [$clog2(DEPTH)-1:0] vict_idx
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   logic             all_valid;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] rr_q;

   assign all_valid = &ent_valid;

   // lowest-numbered free slot
   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!ent_valid[i]) free_idx = IDX_W'(i);
      end
   end

   assign vict_idx = all_valid ? rr_q : free_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rr_q <= '0;
      else if (take && all_valid) rr_q <= (rr_q == LAST) ? '0 : IDX_W'(rr_q + 1'b1);
   end

   p_free_slot_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !all_valid) |-> !ent_valid[vict_idx])
      else $error("victim chose a valid entry while a free one existed");

   p_rr_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (take && all_valid) |=> (rr_q != $past(rr_q)))
      else $error("round-robin pointer did not advance");

   p_rr_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(take && all_valid) |=> $stable(rr_q))
      else $error("round-robin pointer moved without a replacement");
endmodule

// File: rtl/ctx_tlb_store.sv
`timescale 1ns/1ps
module ctx_tlb_store #(
   parameter int DEPTH  = 16,
   parameter int VPN_W  = 20,
   parameter int PPN_W  = 20,
   parameter int CTX_W  = 8,
   parameter int PERM_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_idx,
   input  logic [VPN_W-1:0]         wr_vpn,
   input  logic [CTX_W-1:0]         wr_ctx,
   input  logic                     wr_global,
   input  logic [PPN_W-1:0]         wr_ppn,
   input  logic [PERM_W-1:0]        wr_perm,
   input  logic [DEPTH-1:0]         kill_vec,
   input  logic                     flush,
   output logic [DEPTH-1:0]         ent_valid,
   output logic [DEPTH-1:0]         ent_global,
   output logic [VPN_W-1:0]         ent_vpn  [DEPTH],
   output logic [CTX_W-1:0]         ent_ctx  [DEPTH],
   output logic [PPN_W-1:0]         ent_ppn  [DEPTH],
   output logic [PERM_W-1:0]        ent_perm [DEPTH]
);
   localparam int IDX_W = $clog2(DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_valid  <= '0;
         ent_global <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            ent_vpn[i]  <= '0;
            ent_ctx[i]  <= '0;
            ent_ppn[i]  <= '0;
            ent_perm[i] <= '0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
               ent_valid[i]  <= 1'b1;
               ent_global[i] <= wr_global;
               ent_vpn[i]    <= wr_vpn;
               ent_ctx[i]    <= wr_ctx;
               ent_ppn[i]    <= wr_ppn;
               ent_perm[i]   <= wr_perm;
            end else if (wr_en && kill_vec[i]) begin
               ent_valid[i]  <= 1'b0;   // extra alias of the refilled page
            end else if (flush && !ent_global[i]) begin
               ent_valid[i]  <= 1'b0;
            end
         end
      end
   end

   p_flush_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !wr_en) |=> ((ent_valid & ~ent_global) == '0))
      else $error("non-global entry survived a flush");

   p_global_survives_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !wr_en) |=> ((ent_valid & ent_global) == $past(ent_valid & ent_global)))
      else $error("flush disturbed a global entry");

   p_fill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ent_valid[$past(wr_idx)])
      else $error("filled entry not valid after the write");
endmodule

// File: rtl/ctx_tlb.sv
`timescale 1ns/1ps
module ctx_tlb
   import ctx_tlb_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int CTX_W     = 8,
   parameter int DEPTH     = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [VA_W-1:0]           req_vaddr,
   input  logic [CTX_W-1:0]          req_ctx,
   input  logic [1:0]                req_kind,
   output logic                      resp_hit,
   output logic [PA_W-1:0]           resp_paddr,
   output logic                      resp_perm_fault,
   output logic                      walk_req,
   output logic [VA_W-PAGE_BITS-1:0] walk_vpn,
   input  logic                      fill_valid,
   input  logic                      fill_ok,
   input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
   input  logic [CTX_W-1:0]          fill_ctx,
   input  logic                      fill_global,
   input  logic [PA_W-PAGE_BITS-1:0] fill_ppn,
   input  logic [2:0]                fill_perm,
   input  logic                      base_wr,
   output logic                      page_fault,
   output logic [VA_W-1:0]           fault_vaddr
);
   localparam int VPN_W = VA_W - PAGE_BITS;
   localparam int PPN_W = PA_W - PAGE_BITS;
   localparam int IDX_W = $clog2(DEPTH);

   initial begin
      a_depth: assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      a_page:  assert (PAGE_BITS == 12) else $error("only 4 KiB pages are handled");
      a_va:    assert (VA_W > PAGE_BITS && PA_W > PAGE_BITS) else $error("address narrower than a page");
      a_perm:  assert (PERM_BITS == 3) else $error("permission field must be 3 bits");
   end

   // entry array
   logic [DEPTH-1:0]     ent_valid, ent_global;
   logic [VPN_W-1:0]     ent_vpn  [DEPTH];
   logic [CTX_W-1:0]     ent_ctx  [DEPTH];
   logic [PPN_W-1:0]     ent_ppn  [DEPTH];
   logic [PERM_BITS-1:0] ent_perm [DEPTH];

   // lookup side
   logic [VPN_W-1:0]     lk_vpn;
   logic [PAGE_BITS-1:0] lk_off;
   logic [DEPTH-1:0]     lk_vec;
   logic                 lk_any;
   logic [IDX_W-1:0]     lk_idx;
   logic [PERM_BITS-1:0] lk_perm;
   logic                 lk_allow;

   assign lk_vpn = req_vaddr[VA_W-1:PAGE_BITS];
   assign lk_off = req_vaddr[PAGE_BITS-1:0];

   ctx_tlb_cam #(.DEPTH(DEPTH), .VPN_W(VPN_W), .CTX_W(CTX_W)) lookup_cam_i (
      .ent_valid   (ent_valid),
      .ent_global  (ent_global),
      .ent_vpn     (ent_vpn),
      .ent_ctx     (ent_ctx),
      .key_vpn     (lk_vpn),
      .key_ctx     (req_ctx),
      .key_any_ctx (1'b0),
      .match_vec   (lk_vec),
      .match_any   (lk_any),
      .match_idx   (lk_idx)
   );

   assign resp_hit = req_valid && lk_any && !base_wr;
   assign lk_perm  = ent_perm[lk_idx];

   always_comb begin
      unique case (acc_kind_e'(req_kind))
         ACC_STORE: lk_allow = lk_perm[PERM_WR];
         ACC_FETCH: lk_allow = lk_perm[PERM_EX];
         default:   lk_allow = lk_perm[PERM_RD];
      endcase
   end

   assign resp_perm_fault = resp_hit && !lk_allow;
   assign resp_paddr      = resp_hit ? {ent_ppn[lk_idx], lk_off} : '0;
   assign walk_req        = req_valid && !resp_hit;
   assign walk_vpn        = walk_req ? lk_vpn : '0;

   // refill side
   logic             fill_en, fill_take;
   logic [DEPTH-1:0] fl_vec;
   logic             fl_any;
   logic [IDX_W-1:0] fl_idx, vict_idx, wr_idx;
   logic [DEPTH-1:0] kill_vec;

   assign fill_en = fill_valid && fill_ok;

   ctx_tlb_cam #(.DEPTH(DEPTH), .VPN_W(VPN_W), .CTX_W(CTX_W)) fill_cam_i (
      .ent_valid   (ent_valid),
      .ent_global  (ent_global),
      .ent_vpn     (ent_vpn),
      .ent_ctx     (ent_ctx),
      .key_vpn     (fill_vpn),
      .key_ctx     (fill_ctx),
      .key_any_ctx (fill_global),
      .match_vec   (fl_vec),
      .match_any   (fl_any),
      .match_idx   (fl_idx)
   );

   // pick one of the aliases to overwrite, drop the rest
   logic [IDX_W-1:0] fl_first;
   always_comb begin
      fl_first = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (fl_vec[i]) fl_first = IDX_W'(i);
      end
   end

   assign fill_take = fill_en && !fl_any;
   assign wr_idx    = fl_any ? fl_first : vict_idx;
   assign kill_vec  = fl_vec;

   ctx_tlb_victim #(.DEPTH(DEPTH)) victim_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ent_valid (ent_valid),
      .take      (fill_take),
      .vict_idx  (vict_idx)
   );

   ctx_tlb_store #(
      .DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .CTX_W(CTX_W), .PERM_W(PERM_BITS)
   ) store_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (fill_en),
      .wr_idx     (wr_idx),
      .wr_vpn     (fill_vpn),
      .wr_ctx     (fill_ctx),
      .wr_global  (fill_global),
      .wr_ppn     (fill_ppn),
      .wr_perm    (fill_perm),
      .kill_vec   (kill_vec),
      .flush      (base_wr),
      .ent_valid  (ent_valid),
      .ent_global (ent_global),
      .ent_vpn    (ent_vpn),
      .ent_ctx    (ent_ctx),
      .ent_ppn    (ent_ppn),
      .ent_perm   (ent_perm)
   );

   // failed walk reporting
   logic [VA_W-1:0] miss_va_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        miss_va_q <= '0;
      else if (walk_req) miss_va_q <= req_vaddr;
   end

   assign page_fault  = fill_valid && !fill_ok;
   assign fault_vaddr = page_fault ? miss_va_q : '0;

   p_unique_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_vec))
      else $error("lookup matched more than one entry");

   p_fault_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      resp_perm_fault |-> resp_hit)
      else $error("permission fault without a hit");

   p_miss_walks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !resp_hit) |-> (walk_req && walk_vpn == lk_vpn && resp_paddr == '0))
      else $error("miss without a proper walk request");

   p_flush_cycle_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr |-> !resp_hit)
      else $error("hit reported in a flush cycle");

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!resp_hit && !walk_req && !resp_perm_fault))
      else $error("response activity without a request");

   p_no_fill_on_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (page_fault && !base_wr) |=> (ent_valid == $past(ent_valid)))
      else $error("failed walk changed the entry array");
endmodule

// File: tb/ctx_tlb_tb_top.sv
`timescale 1ns/1ps
module ctx_tlb_tb_top;
   localparam int VA_W = 32, PA_W = 32, CTX_W = 8, DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [7:0]  req_ctx = '0;
   logic [1:0]  req_kind = '0;
   logic        resp_hit, resp_perm_fault, walk_req, page_fault;
   logic [31:0] resp_paddr, fault_vaddr;
   logic [19:0] walk_vpn;
   logic        fill_valid = 1'b0, fill_ok = 1'b0, fill_global = 1'b0, base_wr = 1'b0;
   logic [19:0] fill_vpn = '0, fill_ppn = '0;
   logic [7:0]  fill_ctx = '0;
   logic [2:0]  fill_perm = '0;

   always #10 clk = ~clk;   // 50 MHz

   ctx_tlb #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(12), .CTX_W(CTX_W), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ctx(req_ctx), .req_kind(req_kind),
      .resp_hit(resp_hit), .resp_paddr(resp_paddr), .resp_perm_fault(resp_perm_fault),
      .walk_req(walk_req), .walk_vpn(walk_vpn),
      .fill_valid(fill_valid), .fill_ok(fill_ok), .fill_vpn(fill_vpn), .fill_ctx(fill_ctx),
      .fill_global(fill_global), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
      .base_wr(base_wr), .page_fault(page_fault), .fault_vaddr(fault_vaddr)
   );

   typedef struct {
      logic        hit;
      logic [31:0] pa;
      logic        pfault;
      logic        walk;
      logic [19:0] wvpn;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   function automatic void check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endfunction

   // monitor: compares each lookup result in the middle of its cycle
   always @(negedge clk) begin
      if (rst_n && req_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "SB", "unexpected lookup", 32'd0, 32'd1);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(resp_hit == e.hit, e.tag, "hit", 32'(resp_hit), 32'(e.hit));
            check(resp_paddr == e.pa, e.tag, "paddr", resp_paddr, e.pa);
            check(resp_perm_fault == e.pfault, e.tag, "perm_fault", 32'(resp_perm_fault), 32'(e.pfault));
            check(walk_req == e.walk && (!e.walk || walk_vpn == e.wvpn), e.tag, "walk",
                  {walk_req, 11'd0, walk_vpn}, {e.walk, 11'd0, e.wvpn});
         end
      end
   end

   task automatic clear_inputs();
      req_valid = 0; fill_valid = 0; fill_ok = 0; base_wr = 0; fill_global = 0;
   endtask

   task automatic lookup_x(input logic [31:0] va, input logic [7:0] ctx, input logic [1:0] kind,
                           input bit flush, input bit eh, input logic [19:0] eppn,
                           input bit ef, input string tag);
      exp_t e;
      @(posedge clk); #2;
      clear_inputs();
      req_valid = 1; req_vaddr = va; req_ctx = ctx; req_kind = kind; base_wr = flush;
      e.hit = eh; e.pa = eh ? {eppn, va[11:0]} : 32'd0; e.pfault = ef;
      e.walk = !eh; e.wvpn = va[31:12]; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic lookup(input logic [31:0] va, input logic [7:0] ctx, input logic [1:0] kind,
                         input bit eh, input logic [19:0] eppn, input bit ef, input string tag);
      lookup_x(va, ctx, kind, 1'b0, eh, eppn, ef, tag);
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [7:0] ctx, input bit glob,
                       input logic [19:0] ppn, input logic [2:0] perm);
      @(posedge clk); #2;
      clear_inputs();
      fill_valid = 1; fill_ok = 1; fill_vpn = vpn; fill_ctx = ctx;
      fill_global = glob; fill_ppn = ppn; fill_perm = perm;
   endtask

   task automatic fill_bad(input logic [19:0] vpn, input logic [31:0] exp_va);
      @(posedge clk); #2;
      clear_inputs();
      fill_valid = 1; fill_ok = 0; fill_vpn = vpn;
      @(negedge clk);
      check(page_fault == 1'b1, "R7", "page_fault", 32'(page_fault), 32'd1);
      check(fault_vaddr == exp_va, "R7", "fault_vaddr", fault_vaddr, exp_va);
   endtask

   task automatic idle_check();
      @(posedge clk); #2;
      clear_inputs();
      req_vaddr = 32'h0001_2345; req_ctx = 8'd1;
      @(negedge clk);
      check(!resp_hit && !walk_req && !resp_perm_fault, "R12", "idle outputs",
            {29'd0, resp_hit, walk_req, resp_perm_fault}, 32'd0);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!resp_hit && !page_fault, "R11", "reset outputs", {30'd0, resp_hit, page_fault}, 32'd0);
      rst_n = 1;
      idle_check();
      // R11: empty after reset, R2: miss raises a walk
      lookup(32'h0001_2345, 8'd1, 2'd0, 0, 20'h0, 0, "R2/R11 miss after reset");
      // R5, R1
      fill(20'h00012, 8'd1, 0, 20'hABCDE, 3'b011);
      lookup(32'h0001_2345, 8'd1, 2'd0, 1, 20'hABCDE, 0, "R1/R5 hit after fill");
      lookup(32'h0001_2FF0, 8'd1, 2'd0, 1, 20'hABCDE, 0, "R1 offset passes through");
      // R3
      lookup(32'h0001_2345, 8'd2, 2'd0, 0, 20'h0, 0, "R3 wrong context misses");
      // R6
      lookup(32'h0001_2010, 8'd1, 2'd1, 1, 20'hABCDE, 0, "R6 store with W ok");
      lookup(32'h0001_2010, 8'd1, 2'd2, 1, 20'hABCDE, 1, "R6 fetch without X faults");
      fill(20'h00099, 8'd1, 0, 20'h11111, 3'b001);
      lookup(32'h0009_9004, 8'd1, 2'd1, 1, 20'h11111, 1, "R6 store without W faults");
      lookup(32'h0009_9004, 8'd1, 2'd0, 1, 20'h11111, 0, "R6 load with R ok");
      lookup(32'h0009_9004, 8'd1, 2'd3, 1, 20'h11111, 0, "R6 kind 3 acts as load");
      // R3 global
      fill(20'h00050, 8'd4, 1, 20'h22222, 3'b111);
      lookup(32'h0005_0123, 8'd9, 2'd0, 1, 20'h22222, 0, "R3 global hits any context");
      // R7
      lookup(32'h0077_7ABC, 8'd1, 2'd0, 0, 20'h0, 0, "R2 miss before failed walk");
      fill_bad(20'h00777, 32'h0077_7ABC);
      lookup(32'h0077_7ABC, 8'd1, 2'd0, 0, 20'h0, 0, "R7 nothing inserted");
      // R10 overwrite
      fill(20'h00012, 8'd1, 0, 20'h33333, 3'b011);
      lookup(32'h0001_2345, 8'd1, 2'd0, 1, 20'h33333, 0, "R10 overwrite returns new page");
      // R4 flush
      lookup_x(32'h0005_0123, 8'd9, 2'd0, 1'b1, 0, 20'h0, 0, "R4 lookup in flush cycle misses");
      lookup(32'h0001_2345, 8'd1, 2'd0, 0, 20'h0, 0, "R4 non-global dropped");
      lookup(32'h0009_9004, 8'd1, 2'd0, 0, 20'h0, 0, "R4 non-global dropped 2");
      lookup(32'h0005_0123, 8'd7, 2'd0, 1, 20'h22222, 0, "R4 global kept");
      // R8: fill the 15 free slots, global must survive
      for (int i = 0; i < 15; i++) fill(20'(32'h100 + i), 8'd3, 0, 20'(32'h40000 + i), 3'b001);
      for (int i = 0; i < 15; i++)
         lookup({20'(32'h100 + i), 12'h008}, 8'd3, 2'd0, 1, 20'(32'h40000 + i), 0, "R8 all filled hit");
      lookup(32'h0005_0123, 8'd3, 2'd0, 1, 20'h22222, 0, "R8 no eviction while free");
      // R9: round robin from entry 0 (page 0x100), then 1 (0x101), then 2 (global)
      fill(20'h00200, 8'd3, 0, 20'h50000, 3'b001);
      lookup(32'h0010_0008, 8'd3, 2'd0, 0, 20'h0, 0, "R9 first victim entry 0");
      lookup(32'h0010_1008, 8'd3, 2'd0, 1, 20'h40001, 0, "R9 entry 1 kept");
      lookup(32'h0020_0008, 8'd3, 2'd0, 1, 20'h50000, 0, "R9 new page hits");
      fill(20'h00201, 8'd3, 0, 20'h50001, 3'b001);
      lookup(32'h0010_1008, 8'd3, 2'd0, 0, 20'h0, 0, "R9 second victim entry 1");
      lookup(32'h0005_0123, 8'd3, 2'd0, 1, 20'h22222, 0, "R9 entry 2 kept");
      fill(20'h00202, 8'd3, 0, 20'h50002, 3'b001);
      lookup(32'h0005_0123, 8'd3, 2'd0, 0, 20'h0, 0, "R9 third victim entry 2");
      lookup(32'h0010_2008, 8'd3, 2'd0, 1, 20'h40002, 0, "R9 entry 3 kept");
      idle_check();
      @(posedge clk); #2; clear_inputs();
      repeat (2) @(posedge clk);
      check(exp_q.size() == 0, "SB", "queue drained", 32'(exp_q.size()), 32'd0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule